// File: doc/BRIEF.md
# Paged External Memory Address Mapper

This block sits between an 8051-class processor core and its external data memory, and it builds the 16-bit address for every MOVX transfer. For the register-indirect forms (`@R0`/`@R1`), the low address byte comes from the index register and the high byte comes from a page register held in a special function register. This lets software reach any 256-byte page with single-byte pointers. For the data-pointer forms, the full 16-bit pointer is used and the page register plays no part.

A second register, the data bank, can lay a window of read-only code flash over the external RAM map. While an overlay is active, MOVX reads inside the window are steered to the flash port at a bank-dependent offset, and writes inside the window are dropped. A third register holds the code bank. It is driven out to the fetch logic and is independent of the data bank. The block also decodes the SFR bus for these three registers and returns read data from whichever memory served the previous read.

Top module: `xmem_page_mapper`

## Requirements
- R1: After a synchronous reset, the page register, data bank and code bank all read back 0x00 through the SFR port, and `code_bank` is 0x00.
- R2: The page register sits at SFR address 0x92. A write takes effect on the next cycle, and a read returns the stored value with `sfr_hit` high.
- R3: For a register-indirect access (`mx_ri_sel`=1), the external address is {page, `mx_ri`}.
- R4: For a data-pointer access (`mx_ri_sel`=0), the external address is `mx_dptr` whatever the page register holds.
- R5: SFR address 0xA0 is not decoded. Writing it leaves the page register unchanged, and reading it gives `sfr_hit`=0 and `sfr_rdata`=0x00.
- R6: With data bank 0x00 (SFR 0x97), every access, including one inside 0x4000–0x7FFF, goes to external RAM (`xram_en`=1, `flash_rd`=0).
- R7: With data bank 1, a read in 0x4000–0x7FFF raises only `flash_rd`, with `flash_addr` = 0x04000 + (address − 0x4000).
- R8: With data bank 2, a read in 0x4000–0x7FFF raises only `flash_rd`, with `flash_addr` = 0x10000 + (address − 0x4000).
- R9: An address below 0x4000 or above 0x7FFF always goes to external RAM, whatever the data bank.
- R10: A write inside the window while bank 1 or 2 is active raises neither `xram_en` nor `flash_rd`.
- R11: The code bank sits at SFR 0x96 and drives `code_bank`. Writing it leaves the data bank unchanged, and writing the data bank leaves the code bank unchanged.
- R12: `mx_rdata` one cycle after a read equals `flash_rdata` if that read went to flash, and `xram_rdata` otherwise.
- R13: A data-bank value of 3 or more selects no overlay, so window accesses go to external RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (0 when not decoded) |
| sfr_hit | output | 1 | SFR address belongs to this block |
| code_bank | output | 8 | Current code bank |
| mx_req | input | 1 | MOVX transfer request |
| mx_we | input | 1 | 1 = write, 0 = read |
| mx_ri_sel | input | 1 | 1 = register-indirect form, 0 = data-pointer form |
| mx_ri | input | 8 | Index register value |
| mx_dptr | input | 16 | Data pointer value |
| mx_wdata | input | 8 | Write data from the core |
| mx_rdata | output | 8 | Read data to the core, one cycle after the request |
| xram_en | output | 1 | External RAM access enable |
| xram_we | output | 1 | External RAM write enable |
| xram_addr | output | 16 | External RAM address |
| xram_wdata | output | 8 | External RAM write data |
| xram_rdata | input | 8 | External RAM read data (one-cycle latency) |
| flash_rd | output | 1 | Flash read enable |
| flash_addr | output | 20 | Flash byte address |
| flash_rdata | input | 8 | Flash read data (one-cycle latency) |

## Verification
The bench builds the block with its default parameters: a 16 KiB window at 0x4000, two flash banks spaced on a 64 KiB stride, and a 20-bit flash address. Under these values both window edges (0x3FFF/0x4000 and 0x7FFF/0x8000) can be reached. So can the first bank value that has no flash behind it (3), and a bank-2 address that crosses into bit 16 of the flash address. Random data-bank values are drawn mostly from 0 to 3, so every overlay branch is exercised often.

// File: rtl/xpm_pkg.sv
package xpm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned XA_W   = 16;

    typedef enum logic {
        MX_DPTR = 1'b0,
        MX_RI   = 1'b1
    } mx_form_e;

    typedef struct packed {
        logic [BYTE_W-1:0] page;
        logic [BYTE_W-1:0] dbank;
        logic [BYTE_W-1:0] cbank;
    } xpm_regs_t;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [XA_W-1:0]   addr;
        logic [BYTE_W-1:0] wdata;
    } xpm_req_t;

endpackage

// File: rtl/xpm_sfr_regs.sv
module xpm_sfr_regs
    import xpm_pkg::*;
#(
    parameter logic [7:0] PAGE_ADDR  = 8'h92,
    parameter logic [7:0] DBANK_ADDR = 8'h97,
    parameter logic [7:0] CBANK_ADDR = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    output xpm_regs_t         regs,
    output logic [BYTE_W-1:0] sfr_rdata,
    output logic              sfr_hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (sfr_wr) begin
            case (sfr_addr)
                PAGE_ADDR:  regs.page  <= sfr_wdata;
                DBANK_ADDR: regs.dbank <= sfr_wdata;
                CBANK_ADDR: regs.cbank <= sfr_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        sfr_hit   = 1'b1;
        sfr_rdata = '0;
        case (sfr_addr)
            PAGE_ADDR:  sfr_rdata = regs.page;
            DBANK_ADDR: sfr_rdata = regs.dbank;
            CBANK_ADDR: sfr_rdata = regs.cbank;
            default:    sfr_hit   = 1'b0;
        endcase
    end

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == PAGE_ADDR) |=> regs.page == $past(sfr_wdata)); // R2

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(sfr_wr && sfr_addr == PAGE_ADDR) |=> $stable(regs.page)); // R5

    AST_CBANK_INDEP: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == DBANK_ADDR) |=> $stable(regs.cbank)); // R11

    AST_DBANK_INDEP: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == CBANK_ADDR) |=> $stable(regs.dbank)); // R11

endmodule

// File: rtl/xpm_addr_gen.sv
module xpm_addr_gen
    import xpm_pkg::*;
(
    input  mx_form_e          form,
    input  logic [BYTE_W-1:0] ri,
    input  logic [XA_W-1:0]   dptr,
    input  logic [BYTE_W-1:0] page,
    output logic [XA_W-1:0]   addr
);

    always_comb begin
        unique case (form)
            MX_RI:   addr = {page, ri};
            MX_DPTR: addr = dptr;
        endcase
    end

endmodule

// File: rtl/xpm_bank_route.sv
module xpm_bank_route
    import xpm_pkg::*;
#(
    parameter int unsigned FLASH_AW        = 20,
    parameter logic [15:0] WIN_BASE        = 16'h4000,
    parameter int unsigned WIN_AW          = 14,
    parameter int unsigned NUM_FLASH_BANKS = 2,
    parameter int unsigned BANK_SHIFT      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  xpm_req_t            req,
    input  logic [BYTE_W-1:0]   dbank,
    output logic                xram_en,
    output logic                xram_we,
    output logic [XA_W-1:0]     xram_addr,
    output logic [BYTE_W-1:0]   xram_wdata,
    output logic                flash_rd,
    output logic [FLASH_AW-1:0] flash_addr
);

    localparam logic [BYTE_W-1:0] MAX_BANK = BYTE_W'(NUM_FLASH_BANKS);
    localparam int unsigned       TAG_W    = XA_W - WIN_AW;
    localparam logic [TAG_W-1:0]  WIN_TAG  = WIN_BASE[XA_W-1:WIN_AW];

    logic                in_win;
    logic                bank_ok;
    logic                overlay;
    logic [FLASH_AW-1:0] bank_base;

    always_comb begin
        in_win  = (req.addr[XA_W-1:WIN_AW] == WIN_TAG);
        bank_ok = (dbank != '0) && (dbank <= MAX_BANK);
        overlay = in_win && bank_ok;
        if (dbank == 8'd1)
            bank_base = FLASH_AW'(WIN_BASE);
        else
            bank_base = FLASH_AW'(dbank - 8'd1) << BANK_SHIFT;
    end

    assign flash_rd   = req.valid && overlay && !req.we;
    assign flash_addr = bank_base + FLASH_AW'(req.addr[WIN_AW-1:0]);
    assign xram_en    = req.valid && !overlay;
    assign xram_we    = req.valid && !overlay && req.we;
    assign xram_addr  = req.addr;
    assign xram_wdata = req.wdata;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_rd, xram_en})); // R7

    AST_FLASH_IN_WIN: assert property (@(posedge clk) disable iff (rst)
        flash_rd |-> (req.addr >= WIN_BASE && req.addr <= WIN_BASE + 16'((1 << WIN_AW) - 1))); // R9

    AST_NO_FLASH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.we) |-> !flash_rd); // R10

endmodule

// File: rtl/xmem_page_mapper.sv
module xmem_page_mapper
    import xpm_pkg::*;
#(
    parameter logic [7:0]  PAGE_ADDR       = 8'h92,
    parameter logic [7:0]  DBANK_ADDR      = 8'h97,
    parameter logic [7:0]  CBANK_ADDR      = 8'h96,
    parameter int unsigned FLASH_AW        = 20,
    parameter logic [15:0] WIN_BASE        = 16'h4000,
    parameter int unsigned WIN_AW          = 14,
    parameter int unsigned NUM_FLASH_BANKS = 2,
    parameter int unsigned BANK_SHIFT      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          sfr_addr,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    output logic                sfr_hit,
    output logic [7:0]          code_bank,
    input  logic                mx_req,
    input  logic                mx_we,
    input  logic                mx_ri_sel,
    input  logic [7:0]          mx_ri,
    input  logic [15:0]         mx_dptr,
    input  logic [7:0]          mx_wdata,
    output logic [7:0]          mx_rdata,
    output logic                xram_en,
    output logic                xram_we,
    output logic [15:0]         xram_addr,
    output logic [7:0]          xram_wdata,
    input  logic [7:0]          xram_rdata,
    output logic                flash_rd,
    output logic [FLASH_AW-1:0] flash_addr,
    input  logic [7:0]          flash_rdata
);

    xpm_regs_t       regs;
    xpm_req_t        req;
    logic [XA_W-1:0] eff_addr;
    logic            rd_flash_q;

    xpm_sfr_regs #(
        .PAGE_ADDR  (PAGE_ADDR),
        .DBANK_ADDR (DBANK_ADDR),
        .CBANK_ADDR (CBANK_ADDR)
    ) sfr_i (
        .clk       (clk),
        .rst       (rst),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .regs      (regs),
        .sfr_rdata (sfr_rdata),
        .sfr_hit   (sfr_hit)
    );

    xpm_addr_gen addr_i (
        .form (mx_form_e'(mx_ri_sel)),
        .ri   (mx_ri),
        .dptr (mx_dptr),
        .page (regs.page),
        .addr (eff_addr)
    );

    always_comb begin
        req.valid = mx_req;
        req.we    = mx_we;
        req.addr  = eff_addr;
        req.wdata = mx_wdata;
    end

    xpm_bank_route #(
        .FLASH_AW        (FLASH_AW),
        .WIN_BASE        (WIN_BASE),
        .WIN_AW          (WIN_AW),
        .NUM_FLASH_BANKS (NUM_FLASH_BANKS),
        .BANK_SHIFT      (BANK_SHIFT)
    ) route_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .dbank      (regs.dbank),
        .xram_en    (xram_en),
        .xram_we    (xram_we),
        .xram_addr  (xram_addr),
        .xram_wdata (xram_wdata),
        .flash_rd   (flash_rd),
        .flash_addr (flash_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_flash_q <= 1'b0;
        else if (mx_req && !mx_we)
            rd_flash_q <= flash_rd;
    end

    assign mx_rdata  = rd_flash_q ? flash_rdata : xram_rdata;
    assign code_bank = regs.cbank;

    AST_RI_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mx_req && mx_ri_sel && xram_en) |-> xram_addr == {regs.page, mx_ri}); // R3

    AST_DPTR_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mx_req && !mx_ri_sel && xram_en) |-> xram_addr == mx_dptr); // R4

    AST_RDATA_FLASH: assert property (@(posedge clk) disable iff (rst)
        (mx_req && flash_rd) |=> mx_rdata == flash_rdata); // R12

endmodule

// File: tb/xmem_page_mapper_tb.sv
`timescale 1ns/1ps
module xmem_page_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata, code_bank;
    logic        sfr_wr, sfr_hit;
    logic        mx_req, mx_we, mx_ri_sel;
    logic [7:0]  mx_ri, mx_wdata, mx_rdata;
    logic [15:0] mx_dptr;
    logic        xram_en, xram_we, flash_rd;
    logic [15:0] xram_addr;
    logic [7:0]  xram_wdata, xram_rdata, flash_rdata;
    logic [19:0] flash_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_page, m_dbank, m_cbank;
    logic [7:0] xmem [0:1023];

    always #4 clk = ~clk;

    xmem_page_mapper dut_i (
        .clk(clk), .rst(rst),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit), .code_bank(code_bank),
        .mx_req(mx_req), .mx_we(mx_we), .mx_ri_sel(mx_ri_sel), .mx_ri(mx_ri),
        .mx_dptr(mx_dptr), .mx_wdata(mx_wdata), .mx_rdata(mx_rdata),
        .xram_en(xram_en), .xram_we(xram_we), .xram_addr(xram_addr),
        .xram_wdata(xram_wdata), .xram_rdata(xram_rdata),
        .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_rdata(flash_rdata)
    );

    function automatic logic [7:0] fhash(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] xhash(logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h11;
    endfunction

    function automatic logic [7:0] xread(logic [15:0] a);
        return (a < 16'h0400) ? xmem[a[9:0]] : xhash(a);
    endfunction

    // memory models with one-cycle read latency
    always @(posedge clk) begin
        if (xram_en) begin
            if (xram_we && xram_addr < 16'h0400) xmem[xram_addr[9:0]] <= xram_wdata;
            xram_rdata <= xread(xram_addr);
        end
        if (flash_rd) flash_rdata <= fhash(flash_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
        if (a == 8'h92) m_page  = d;
        if (a == 8'h97) m_dbank = d;
        if (a == 8'h96) m_cbank = d;
    endtask

    task automatic sfr_check(input logic [7:0] a, input logic [7:0] exp, input bit exp_hit, input string tag);
        sfr_addr = a; sfr_wr = 1'b0;
        #1;
        chk(sfr_rdata == exp, tag, sfr_rdata, exp);
        chk(sfr_hit == exp_hit, tag, sfr_hit, exp_hit);
    endtask

    // one MOVX transfer, all routing expectations computed from the requirements
    task automatic movx(input bit we, input bit ri_sel, input logic [7:0] ri,
                        input logic [15:0] dptr, input logic [7:0] wd, input string tag);
        logic [15:0] ea;
        bit          in_win, ov, exp_fl, exp_xr;
        logic [19:0] exp_fa;
        logic [7:0]  exp_rd;
        ea     = ri_sel ? {m_page, ri} : dptr;                       // R3, R4
        in_win = (ea >= 16'h4000) && (ea <= 16'h7FFF);               // R9
        ov     = in_win && (m_dbank == 8'd1 || m_dbank == 8'd2);     // R6, R13
        exp_fl = ov && !we;
        exp_xr = !ov;                                                // R10
        exp_fa = (m_dbank == 8'd1) ? (20'h04000 + 20'(ea - 16'h4000))   // R7
                                   : (20'h10000 + 20'(ea - 16'h4000));  // R8
        exp_rd = exp_fl ? fhash(exp_fa) : xread(ea);
        @(negedge clk);
        mx_req = 1'b1; mx_we = we; mx_ri_sel = ri_sel; mx_ri = ri; mx_dptr = dptr; mx_wdata = wd;
        #2;
        chk(flash_rd == exp_fl, tag, flash_rd, exp_fl);
        chk(xram_en == exp_xr, tag, xram_en, exp_xr);
        if (exp_xr) begin
            chk(xram_addr == ea, tag, xram_addr, ea);
            chk(xram_we == we, tag, xram_we, we);
            if (we) chk(xram_wdata == wd, tag, xram_wdata, wd);
        end
        if (exp_fl) chk(flash_addr == exp_fa, tag, flash_addr, exp_fa);
        @(negedge clk);
        mx_req = 1'b0; mx_we = 1'b0;
        #1;
        if (!we && (exp_fl || exp_xr))
            chk(mx_rdata == exp_rd, {tag, "/R12"}, mx_rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20251216);
        for (int i = 0; i < 1024; i++) xmem[i] = 8'h00;
        m_page = 8'h00; m_dbank = 8'h00; m_cbank = 8'h00;
        rst = 1'b1; sfr_addr = 8'h00; sfr_wr = 1'b0; sfr_wdata = 8'h00;
        mx_req = 1'b0; mx_we = 1'b0; mx_ri_sel = 1'b0; mx_ri = 8'h00;
        mx_dptr = 16'h0000; mx_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        sfr_check(8'h92, 8'h00, 1'b1, "R1 page");
        sfr_check(8'h97, 8'h00, 1'b1, "R1 dbank");
        sfr_check(8'h96, 8'h00, 1'b1, "R1 cbank");
        chk(code_bank == 8'h00, "R1 code_bank", code_bank, 8'h00);

        // R2 page register write/read
        sfr_write(8'h92, 8'hC3);
        sfr_check(8'h92, 8'hC3, 1'b1, "R2");

        // R3/R4: distinct patterns via @Ri on page 0 and page 1, read back by DPTR
        sfr_write(8'h92, 8'h00);
        for (int i = 0; i < 16; i++) movx(1'b1, 1'b1, 8'(8'h20 + i), 16'h0, 8'(8'h10 + i), "R3 wr p0");
        sfr_write(8'h92, 8'h01);
        for (int i = 0; i < 16; i++) movx(1'b1, 1'b1, 8'(8'h20 + i), 16'h0, 8'(8'h80 + i), "R3 wr p1");
        sfr_write(8'h92, 8'h05);
        for (int i = 0; i < 16; i++) begin
            movx(1'b0, 1'b0, 8'h00, 16'(16'h0020 + i), 8'h00, "R4 rd 00xx");
            chk(mx_rdata == 8'(8'h10 + i), "R3 landed 0x00xx", mx_rdata, 8'(8'h10 + i));
            movx(1'b0, 1'b0, 8'h00, 16'(16'h0120 + i), 8'h00, "R4 rd 01xx");
            chk(mx_rdata == 8'(8'h80 + i), "R3 landed 0x01xx", mx_rdata, 8'(8'h80 + i));
        end

        // R5 port-2 address not decoded
        sfr_write(8'h92, 8'h01);
        sfr_write(8'hA0, 8'h33);
        sfr_check(8'hA0, 8'h00, 1'b0, "R5 A0 read");
        sfr_check(8'h92, 8'h01, 1'b1, "R5 page kept");
        movx(1'b0, 1'b1, 8'h2F, 16'h0, 8'h00, "R5 Ri uses page 1");

        // R6 .. R10, R13 directed overlay corners
        sfr_write(8'h97, 8'h00);
        movx(1'b0, 1'b0, 8'h00, 16'h4123, 8'h00, "R6 bank0 window");
        sfr_write(8'h97, 8'h01);
        movx(1'b0, 1'b0, 8'h00, 16'h4123, 8'h00, "R7 bank1");
        movx(1'b0, 1'b0, 8'h00, 16'h4000, 8'h00, "R7 bank1 low edge");
        sfr_write(8'h97, 8'h02);
        movx(1'b0, 1'b0, 8'h00, 16'h7FFF, 8'h00, "R8 bank2 high edge");
        movx(1'b0, 1'b0, 8'h00, 16'h3FFF, 8'h00, "R9 below window");
        movx(1'b0, 1'b0, 8'h00, 16'h8000, 8'h00, "R9 above window");
        movx(1'b1, 1'b0, 8'h00, 16'h4000, 8'hEE, "R10 window write dropped");
        sfr_write(8'h92, 8'h45);
        movx(1'b0, 1'b1, 8'h67, 16'h0, 8'h00, "R8 Ri into window");
        sfr_write(8'h97, 8'h03);
        movx(1'b0, 1'b0, 8'h00, 16'h4000, 8'h00, "R13 bank3 no overlay");

        // R11 code bank independence
        sfr_write(8'h96, 8'h5A);
        #1 chk(code_bank == 8'h5A, "R11 code_bank out", code_bank, 8'h5A);
        sfr_check(8'h97, 8'h03, 1'b1, "R11 dbank kept");
        sfr_write(8'h97, 8'h01);
        #1 chk(code_bank == 8'h5A, "R11 cbank kept", code_bank, 8'h5A);
        sfr_check(8'h96, 8'h5A, 1'b1, "R11 cbank read");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic [15:0] d;
            r = $urandom % 8;
            if (r == 0) sfr_write(8'h92, 8'($urandom));
            else if (r == 1) sfr_write(8'h97, ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % 4));
            else if (r == 2) sfr_write(($urandom % 2) ? 8'hA0 : 8'h96, 8'($urandom));
            d = ($urandom % 2) ? 16'(16'h4000 + ($urandom % 16'h4000))
              : (($urandom % 2) ? 16'($urandom % 16'h0400) : 16'($urandom));
            movx(($urandom % 3) == 0, ($urandom % 2) == 1, 8'($urandom), d, 8'($urandom),
                 "R3/R4/R6/R7/R8/R9/R10/R13 random");
        end
        sfr_check(8'h92, m_page, 1'b1, "R2 random final page");
        sfr_check(8'h96, m_cbank, 1'b1, "R11 random final cbank");

        finish_run();
    end

endmodule